// File: doc/BRIEF.md
# Partitioned Register Window Address Mapper

This block converts a logical register number (0 to 31) and a logical window number into a flat index into a physical register file. That file holds eight globals followed by sixteen registers per physical window. In normal mode every physical window takes part in one ring. The outs of window `w` are the same storage as the ins of window `w-1`, modulo the window count. Locals are private to each window.

A small configuration register can select a contiguous run of physical windows, starting at a chosen window and spanning a chosen number of logical windows. That run then behaves as a complete register file: logical window `k` lands on physical window `start+k`, and the ring closes inside the run. Windows outside the run cannot be addressed, so their contents are kept. A write whose window-maximum field is zero changes only the alternate window pointer and leaves the partition alone. Settings that would run past the last physical window raise a flag, and the mapper falls back to normal mode while that flag is set.

The lookup is purely combinational. It has no data stream, so it carries no valid/ready handshake. The configuration port is a plain write strobe, and a write takes effect from the cycle after its clock edge.

Top module: `pwin_map`

## Requirements
- R1: Register numbers 0 to 7 are globals. They map to index equal to the register number, whatever the window and mode.
- R2: `o_zero` is 1 exactly when `i_reg` is 0.
- R3: In the effective mode, with physical window `p`, locals 16..23 map to `8 + 16*p + (reg-16)` and ins 24..31 map to `8 + 16*p + 8 + (reg-24)`.
- R4: In normal mode `p` equals the window, clamped to `NWIN-1`. Outs 8..15 of window `w` map to the ins of window `(w-1) mod NWIN`, so the outs of window 0 alias the ins of window `NWIN-1`.
- R5: With partitioning active, logical window `k` maps to physical window `start+k`. A logical window above the stored maximum is clamped to the maximum.
- R6: With partitioning active, the outs of logical window 0 alias the ins of logical window `max`, at physical window `start+max`. The outs of any other logical window `k` alias the ins of physical window `start+k-1`.
- R7: With partitioning active, every windowed register (8..31) maps inside physical windows `start` to `start+max`.
- R8: Partitioning is active only when the stored enable is 1, the stored maximum is nonzero, and the configuration is legal. Otherwise the mapping is normal.
- R9: `o_illegal` is 1 exactly when the stored `start + max` exceeds `NWIN-1`.
- R10: A write (`cfg_we`=1) with nonzero `cfg_cwpmax` stores enable, start, maximum and alternate pointer. The new values steer the mapping from the next cycle.
- R11: A write with `cfg_cwpmax`=0 stores only the alternate pointer, which shows on `o_awp`. Enable, start and maximum keep their stored values.
- R12: After reset, enable, start, maximum and alternate pointer are 0. The mapping is normal and `o_illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i_win | input | WIN_W | Logical window number |
| i_reg | input | 5 | Logical register number |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Partition enable bit to store |
| cfg_stwin | input | WIN_W | Start physical window to store |
| cfg_cwpmax | input | WIN_W | Highest logical window; 0 means update only the alternate pointer |
| cfg_awp | input | WIN_W | Alternate window pointer to store |
| o_idx | output | IDX_W | Physical register-file index |
| o_zero | output | 1 | Register 0 selected; reads as zero |
| o_illegal | output | 1 | Stored partition runs past the last window |
| o_awp | output | WIN_W | Stored alternate window pointer |

## Verification
A configuration write and a lookup can fall in the same cycle. The lookup in that cycle must still use the old settings, and the new settings must steer the lookup on the following cycle. The bench provokes this on purpose and at random: it writes while presenting a lookup, checks the index against the previously stored settings, and then repeats the same lookup one cycle later against the new ones. A pointer-only write issued while a partition is active is judged the same way, since the mapping must not move at all.

// File: rtl/pwin_pkg.sv
package pwin_pkg;
  localparam int NGLOB    = 8;
  localparam int WIN_REGS = 16;
  localparam int REG_W    = 5;

  typedef enum logic [1:0] {
    RC_GLOBAL = 2'd0,
    RC_OUT    = 2'd1,
    RC_LOCAL  = 2'd2,
    RC_IN     = 2'd3
  } reg_class_e;

  function automatic reg_class_e classify(input logic [REG_W-1:0] r);
    case (r[4:3])
      2'd0:    return RC_GLOBAL;
      2'd1:    return RC_OUT;
      2'd2:    return RC_LOCAL;
      default: return RC_IN;
    endcase
  endfunction
endpackage

// File: rtl/pwin_cfg.sv
module pwin_cfg #(
  parameter int NWIN  = 8,
  parameter int WIN_W = $clog2(NWIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_en,
  input  logic [WIN_W-1:0] cfg_stwin,
  input  logic [WIN_W-1:0] cfg_cwpmax,
  input  logic [WIN_W-1:0] cfg_awp,
  output logic             st_en,
  output logic [WIN_W-1:0] st_stwin,
  output logic [WIN_W-1:0] st_cmax,
  output logic [WIN_W-1:0] st_awp,
  output logic             illegal,
  output logic             part_act
);
  localparam logic [WIN_W:0] TOP_WIN = (WIN_W+1)'(NWIN-1);

  logic            full_wr;
  logic [WIN_W:0]  span_end;

  assign full_wr = cfg_we && (cfg_cwpmax != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_en    <= 1'b0;
      st_stwin <= '0;
      st_cmax  <= '0;
      st_awp   <= '0;
    end else begin
      if (cfg_we) st_awp <= cfg_awp;
      if (full_wr) begin
        st_en    <= cfg_en;
        st_stwin <= cfg_stwin;
        st_cmax  <= cfg_cwpmax;
      end
    end
  end

  assign span_end = {1'b0, st_stwin} + {1'b0, st_cmax};
  assign illegal  = span_end > TOP_WIN;
  assign part_act = st_en && (st_cmax != '0) && !illegal;
endmodule

// File: rtl/pwin_sel.sv
module pwin_sel #(
  parameter int NWIN  = 8,
  parameter int WIN_W = $clog2(NWIN)
) (
  input  logic [WIN_W-1:0] i_win,
  input  logic             part_act,
  input  logic [WIN_W-1:0] st_stwin,
  input  logic [WIN_W-1:0] st_cmax,
  output logic [WIN_W-1:0] pw_cur,
  output logic [WIN_W-1:0] pw_prev
);
  localparam logic [WIN_W-1:0] LAST = WIN_W'(NWIN-1);

  logic [WIN_W-1:0] top_l, base, lw, lprev;

  always_comb begin
    top_l = part_act ? st_cmax  : LAST;
    base  = part_act ? st_stwin : '0;
    lw    = (i_win > top_l) ? top_l : i_win;
    lprev = (lw == '0) ? top_l : lw - 1'b1;
    pw_cur  = base + lw;
    pw_prev = base + lprev;
  end
endmodule

// File: rtl/pwin_idx.sv
module pwin_idx
  import pwin_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int WIN_W = $clog2(NWIN),
  parameter int IDX_W = $clog2(NGLOB + NWIN*WIN_REGS)
) (
  input  logic [REG_W-1:0] i_reg,
  input  logic [WIN_W-1:0] pw_cur,
  input  logic [WIN_W-1:0] pw_prev,
  output logic [IDX_W-1:0] o_idx
);
  localparam int HALF = WIN_REGS / 2;

  reg_class_e       rc;
  logic [IDX_W-1:0] sub;
  logic [WIN_W-1:0] pw;
  logic [IDX_W-1:0] win_base;

  always_comb begin
    rc  = classify(i_reg);
    sub = IDX_W'(i_reg[2:0]);
    pw  = (rc == RC_OUT) ? pw_prev : pw_cur;
    win_base = IDX_W'(NGLOB) + IDX_W'(int'(pw) * WIN_REGS);
    case (rc)
      RC_GLOBAL: o_idx = IDX_W'(i_reg);
      RC_LOCAL:  o_idx = win_base + sub;
      default:   o_idx = win_base + IDX_W'(HALF) + sub;
    endcase
  end
endmodule

// File: rtl/pwin_map.sv
module pwin_map
  import pwin_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int WIN_W = $clog2(NWIN),
  parameter int IDX_W = $clog2(NGLOB + NWIN*WIN_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] i_win,
  input  logic [4:0]       i_reg,
  input  logic             cfg_we,
  input  logic             cfg_en,
  input  logic [WIN_W-1:0] cfg_stwin,
  input  logic [WIN_W-1:0] cfg_cwpmax,
  input  logic [WIN_W-1:0] cfg_awp,
  output logic [IDX_W-1:0] o_idx,
  output logic             o_zero,
  output logic             o_illegal,
  output logic [WIN_W-1:0] o_awp
);
  logic             st_en, illegal, part_act;
  logic [WIN_W-1:0] st_stwin, st_cmax, st_awp;
  logic [WIN_W-1:0] pw_cur, pw_prev;

  pwin_cfg #(.NWIN(NWIN), .WIN_W(WIN_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .cfg_stwin(cfg_stwin), .cfg_cwpmax(cfg_cwpmax), .cfg_awp(cfg_awp),
    .st_en(st_en), .st_stwin(st_stwin), .st_cmax(st_cmax), .st_awp(st_awp),
    .illegal(illegal), .part_act(part_act)
  );

  pwin_sel #(.NWIN(NWIN), .WIN_W(WIN_W)) u_sel (
    .i_win(i_win), .part_act(part_act), .st_stwin(st_stwin),
    .st_cmax(st_cmax), .pw_cur(pw_cur), .pw_prev(pw_prev)
  );

  pwin_idx #(.NWIN(NWIN), .WIN_W(WIN_W), .IDX_W(IDX_W)) u_idx (
    .i_reg(i_reg), .pw_cur(pw_cur), .pw_prev(pw_prev), .o_idx(o_idx)
  );

  assign o_zero    = (i_reg == 5'd0);
  assign o_illegal = illegal;
  assign o_awp     = st_awp;
endmodule

// File: rtl/pwin_map_chk.sv
module pwin_map_chk #(
  parameter int NWIN  = 8,
  parameter int WIN_W = $clog2(NWIN),
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [4:0]       i_reg,
  input logic [WIN_W-1:0] i_win,
  input logic             cfg_we,
  input logic             cfg_en,
  input logic [WIN_W-1:0] cfg_stwin,
  input logic [WIN_W-1:0] cfg_cwpmax,
  input logic [WIN_W-1:0] cfg_awp,
  input logic [IDX_W-1:0] o_idx,
  input logic             o_illegal,
  input logic [WIN_W-1:0] o_awp,
  input logic             st_en,
  input logic [WIN_W-1:0] st_stwin,
  input logic [WIN_W-1:0] st_cmax,
  input logic             part_act
);
  int lo, hi;
  assign lo = 8 + 16*int'(st_stwin);
  assign hi = 8 + 16*(int'(st_stwin) + int'(st_cmax) + 1);

  assert_globals_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (i_reg < 5'd8) |-> (o_idx == IDX_W'(i_reg)));

  assert_ring_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (part_act && i_reg[4:3] == 2'd1 && i_win == '0) |->
    (int'(o_idx) == 8 + 16*(int'(st_stwin)+int'(st_cmax)) + 8 + int'(i_reg[2:0])));

  assert_isolation_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (part_act && i_reg >= 5'd8) |-> (int'(o_idx) >= lo && int'(o_idx) < hi));

  assert_illegal_needs_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
    o_illegal |-> (st_cmax != '0));

  assert_full_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_cwpmax != '0) |=>
    (st_stwin == $past(cfg_stwin) && st_cmax == $past(cfg_cwpmax) && st_en == $past(cfg_en)));

  assert_awp_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_cwpmax == '0) |=>
    ($stable(st_stwin) && $stable(st_cmax) && $stable(st_en) && o_awp == $past(cfg_awp)));
endmodule

bind pwin_map pwin_map_chk #(.NWIN(NWIN), .WIN_W(WIN_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .i_reg(i_reg), .i_win(i_win), .cfg_we(cfg_we),
  .cfg_en(cfg_en), .cfg_stwin(cfg_stwin), .cfg_cwpmax(cfg_cwpmax),
  .cfg_awp(cfg_awp), .o_idx(o_idx), .o_illegal(o_illegal), .o_awp(o_awp),
  .st_en(st_en), .st_stwin(st_stwin), .st_cmax(st_cmax), .part_act(part_act)
);

// File: tb/pwin_map_tb.sv
module pwin_map_tb;
  localparam int NWIN = 8;
  localparam int WW   = 3;
  localparam int IW   = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [WW-1:0] i_win = '0;
  logic [4:0]    i_reg = '0;
  logic          cfg_we = 1'b0, cfg_en = 1'b0;
  logic [WW-1:0] cfg_stwin = '0, cfg_cwpmax = '0, cfg_awp = '0;
  logic [IW-1:0] o_idx;
  logic          o_zero, o_illegal;
  logic [WW-1:0] o_awp;

  int errors = 0, checks = 0;
  int m_en = 0, m_st = 0, m_cm = 0, m_awp = 0;

  always #2.5 clk = ~clk;

  pwin_map #(.NWIN(NWIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .i_win(i_win), .i_reg(i_reg), .cfg_we(cfg_we),
    .cfg_en(cfg_en), .cfg_stwin(cfg_stwin), .cfg_cwpmax(cfg_cwpmax),
    .cfg_awp(cfg_awp), .o_idx(o_idx), .o_zero(o_zero), .o_illegal(o_illegal),
    .o_awp(o_awp)
  );

  function automatic int exp_idx(int w, int r);
    bit bad = (m_st + m_cm) > NWIN-1;
    bit part = (m_en != 0) && (m_cm != 0) && !bad;
    int n = part ? m_cm + 1 : NWIN;
    int off = part ? m_st : 0;
    int lw = (w > n-1) ? n-1 : w;
    if (r < 8) return r;
    if (r >= 24) return 8 + (off+lw)*16 + 8 + (r-24);
    if (r >= 16) return 8 + (off+lw)*16 + (r-16);
    return 8 + (off + (lw+n-1)%n)*16 + 8 + (r-8);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive at negedge, check 1 ns later, then fold any write into the model.
  task automatic step(input int w, input int r, input bit we, input int en,
                      input int st, input int cm, input int awp, input string req);
    @(negedge clk);
    i_win = WW'(w); i_reg = 5'(r); cfg_we = we; cfg_en = en[0];
    cfg_stwin = WW'(st); cfg_cwpmax = WW'(cm); cfg_awp = WW'(awp);
    #1;
    chk(req, int'(o_idx), exp_idx(w, r));
    chk("R2", int'(o_zero), (r == 0) ? 1 : 0);
    chk("R9", int'(o_illegal), ((m_st + m_cm) > NWIN-1) ? 1 : 0);
    chk("R11", int'(o_awp), m_awp);
    if (we) begin
      m_awp = awp;
      if (cm != 0) begin m_en = en; m_st = st; m_cm = cm; end
    end
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    #1;
    chk("R12", int'(o_illegal), 0);
    chk("R12", int'(o_awp), 0);
    chk("R12", int'(o_idx), 0);
    rst_n = 1'b1;
    // R12: reset state gives normal mapping; R4 outs of window 0 alias ins of window 7
    step(0, 8, 0, 0, 0, 0, 0, "R4");
    chk("R4", int'(o_idx), 8 + 7*16 + 8);
    step(3, 17, 0, 0, 0, 0, 0, "R3");
    chk("R3", int'(o_idx), 8 + 48 + 1);
    step(5, 5, 0, 0, 0, 0, 0, "R1");
    // R10: write a partition start=2 max=3 while looking up: old mapping still holds
    step(0, 8, 1, 1, 2, 3, 1, "R10");
    chk("R10", int'(o_idx), 8 + 7*16 + 8);
    // R6: next cycle outs of logical 0 are ins of physical 5
    step(0, 8, 0, 0, 0, 0, 0, "R6");
    chk("R6", int'(o_idx), 8 + 5*16 + 8);
    step(2, 12, 0, 0, 0, 0, 0, "R6");
    chk("R6", int'(o_idx), 8 + 3*16 + 8 + 4);
    // R5: logical window 6 above max clamps to 3 -> physical 5
    step(6, 30, 0, 0, 0, 0, 0, "R5");
    chk("R5", int'(o_idx), 8 + 5*16 + 8 + 6);
    // R11: pointer-only write leaves partition in place
    step(1, 16, 1, 0, 7, 0, 6, "R11");
    step(1, 16, 0, 0, 0, 0, 0, "R11");
    chk("R11", int'(o_idx), 8 + 3*16);
    chk("R11", int'(o_awp), 6);
    // R9/R8: illegal start=6 max=3 -> flag and normal mapping
    step(0, 0, 1, 1, 6, 3, 0, "R1");
    step(2, 20, 0, 0, 0, 0, 0, "R8");
    chk("R9", int'(o_illegal), 1);
    chk("R8", int'(o_idx), 8 + 32 + 4);
    // R8: enable clear -> normal
    step(0, 0, 1, 0, 1, 2, 0, "R1");
    step(1, 25, 0, 0, 0, 0, 0, "R8");
    chk("R8", int'(o_idx), 8 + 16 + 8 + 1);
    // Random mix (R3..R11), including same-cycle write and lookup
    for (int k = 0; k < 3000; k++) begin
      int w = int'($urandom_range(NWIN-1));
      int r = int'($urandom_range(31));
      bit we = ($urandom_range(3) == 0);
      int cm = ($urandom_range(4) == 0) ? 0 : int'($urandom_range(NWIN-1));
      int st = int'($urandom_range(NWIN-1));
      step(w, r, we, int'($urandom_range(3) != 0), st, cm,
           int'($urandom_range(NWIN-1)), (r < 8) ? "R1" : "R7");
      if (m_en != 0 && m_cm != 0 && (m_st + m_cm) <= NWIN-1 && r >= 8 && !we)
        chk("R7", (int'(o_idx) >= 8 + 16*m_st &&
                   int'(o_idx) < 8 + 16*(m_st+m_cm+1)) ? 1 : 0, 1);
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule